// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block turns 16-bit host words into a bipolar Manchester II line signal. Each word goes out as a framed transmission: a three-bit-time synchronization pattern that marks the word as either a command or a data word, then the sixteen data bits with the most significant bit first, then one odd-parity bit. The host does not load the word in parallel. It watches a data-request output and shifts bits in serially on a shift clock that the block produces at the bit rate.

The block runs from a clock at twice the bit rate, so each clock edge is one half-bit. As a build option, a divide-by-six prescaler can take a faster clock and produce that half-bit rate from it. If the enable stays high, words follow one another with no gap. A low on the active-low inhibit input forces both line outputs high and leaves all internal state alone. A pulse on the abort input returns the block to idle at the next clock edge.

Top module: `manch_encoder`

## Requirements
- R1: `shift_clk_o` changes level on every half-bit tick. It is low in the first half of each bit period and high in the second half, so each falling edge marks a bit-period boundary.
- R2: A word cycle starts at a falling shift-clock edge where `enc_en_i` is high, and lasts 20 bit periods. The first of these periods is a lead-in: it carries nothing, or the parity bit of the previous word.
- R3: `sync_cmd_i` is sampled at the rising shift-clock edge of the lead-in period. Bit periods 1 to 3 then carry the sync: for value 1 (command), three half-bits high followed by three half-bits low; for value 0 (data), the inverse.
- R4: `data_req_o` is high for exactly 16 bit periods (periods 3 to 18). `sdata_i` is sampled at each falling shift-clock edge that ends one of those periods, and the first bit sampled is the word's most significant bit.
- R5: Each data bit takes one bit period (periods 4 to 19). A 1 is high in the first half and low in the second half; a 0 is the reverse.
- R6: The bit period after the last data bit carries the parity bit, encoded like a data bit. The parity bit is 1 when the data word has an even number of ones, which makes the total count of ones odd.
- R7: If `enc_en_i` is high at the falling edge that ends period 19, the next word's cycle starts there: its lead-in period carries the parity bit and its sync follows at once. If the enable is low at that edge, the line goes idle after the parity bit.
- R8: While `inhibit_n_i` is low, both line outputs are high. The frame carries on underneath and reappears unchanged when the inhibit is released.
- R9: A high `mr_i` at a clock edge aborts any word. After that edge both line outputs are low, `data_req_o` is low, `shift_clk_o` is low, and a new word needs the enable again.
- R10: When nothing is being sent and inhibit is inactive, both line outputs are low. While a word is being sent, `line_neg_o` is the complement of `line_pos_o`.
- R11: With the prescaler option selected, one half-bit takes six input clocks, so `shift_clk_o` changes level every six clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Half-bit clock, or the fast clock when the prescaler is selected |
| rst_i | input | 1 | Synchronous active-high reset |
| mr_i | input | 1 | Abort; returns the encoder to idle at the next clock edge |
| enc_en_i | input | 1 | Starts a word at a falling shift-clock edge; kept high for back-to-back words |
| sync_cmd_i | input | 1 | 1 selects command sync, 0 selects data sync |
| sdata_i | input | 1 | Serial data from the host, most significant bit first |
| inhibit_n_i | input | 1 | Active-low output inhibit; low forces both line outputs high |
| shift_clk_o | output | 1 | Shift clock at the bit rate |
| data_req_o | output | 1 | High while the encoder wants the 16 data bits |
| line_pos_o | output | 1 | Bipolar line output carrying the true Manchester level |
| line_neg_o | output | 1 | Bipolar line output carrying the complementary level |

## Verification
A wrong half-bit counter or a wrong enable decision moves a sync edge or a data transition. That shows on the line outputs in the very half-bit where it happens, because the bench compares both outputs with its queue-based model on every clock. A fault in the parity accumulator stays hidden until the parity period of the same word and then shows there. A shift-clock phase that drifts, or a data-request window that is one period long or short, shows within one bit period: through the shift-clock comparison, the request-length count, or data bits landing shifted by one position. A bad prescaler count shows as a toggle spacing other than six clocks.

// File: rtl/manch_enc_pkg.sv
package manch_enc_pkg;

    localparam int WORD_BITS     = 16;
    localparam int SYNC_BITS     = 3;
    localparam int LEAD_PERIODS  = 1;
    localparam int FRAME_PERIODS = LEAD_PERIODS + SYNC_BITS + WORD_BITS;
    localparam int FRAME_HALVES  = 2 * FRAME_PERIODS;
    localparam int SYNC_FIRST    = 2 * LEAD_PERIODS;
    localparam int DATA_FIRST    = SYNC_FIRST + 2 * SYNC_BITS;
    localparam int REQ_FIRST     = DATA_FIRST - 2;
    localparam int REQ_LAST      = FRAME_HALVES - 3;
    localparam int HALF_W        = $clog2(FRAME_HALVES);

    typedef logic [HALF_W-1:0] half_t;

    // What the line carries during the coming half-bit
    typedef enum logic [1:0] {
        HK_IDLE,
        HK_SYNC,
        HK_DATA,
        HK_PARITY
    } half_kind_e;

    typedef struct packed {
        half_kind_e kind;
        half_t      idx;    // half-bit index inside its segment
        logic       first;  // coming half is the first half of a bit period
    } half_cmd_t;

    // Sync shape: first SYNC_BITS halves carry cmd, the rest its inverse
    function automatic logic sync_level(input logic cmd, input half_t idx);
        return (int'(idx) < SYNC_BITS) ? cmd : ~cmd;
    endfunction

    // Odd parity from the running XOR of the data bits
    function automatic logic odd_parity_bit(input logic xor_acc);
        return ~xor_acc;
    endfunction

endpackage

// File: rtl/manch_half_tick.sv
module manch_half_tick #(
    parameter bit USE_PRESCALER = 1'b0,
    parameter int DIV           = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    output logic tick_o,
    output logic ph_o
);

    generate
        if (USE_PRESCALER) begin : g_div
            localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk_i) begin
                if (rst_i || clr_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == CW'(DIV - 1));

            // R11: divider never leaves its range
            a_r11_div_range: assert property (@(posedge clk_i) disable iff (rst_i)
                cnt_q <= CW'(DIV - 1));
        end else begin : g_pass
            assign tick_o = 1'b1;
        end
    endgenerate

    logic ph_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            ph_q <= 1'b0;
        end else if (tick_o) begin
            ph_q <= ~ph_q;
        end
    end

    assign ph_o = ph_q;

    // R1: shift-clock phase flips on every half-bit tick
    a_r1_phase_flip: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_o && !clr_i) |=> (ph_o != $past(ph_o)));

endmodule

// File: rtl/manch_frame_seq.sv
module manch_frame_seq
    import manch_enc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      clr_i,
    input  logic      tick_i,
    input  logic      ph_i,
    input  logic      en_i,
    input  logic      sel_i,
    output half_cmd_t nx_o,
    output logic      cmd_o,
    output logic      req_o
);

    logic  active_q, active_d;
    logic  pend_q, pend_d;
    half_t half_q, half_d;
    logic  cmd_q;
    logic  boundary;
    logic  last_half;

    // A tick while the phase is high ends a bit period (falling shift clock)
    assign boundary  = tick_i & ph_i;
    assign last_half = active_q && (half_q == half_t'(FRAME_HALVES - 1));

    always_comb begin
        active_d = active_q;
        half_d   = half_q;
        pend_d   = pend_q;
        if (tick_i) begin
            if (boundary) begin
                pend_d = 1'b0;
            end
            if (active_q) begin
                if (last_half) begin
                    pend_d   = 1'b1;
                    half_d   = '0;
                    active_d = en_i;
                end else begin
                    half_d = half_q + 1'b1;
                end
            end else if (boundary && en_i) begin
                active_d = 1'b1;
                half_d   = '0;
            end
        end
    end

    always_comb begin
        nx_o.first = ph_i;
        nx_o.kind  = HK_IDLE;
        nx_o.idx   = '0;
        if (active_d && (half_d >= half_t'(DATA_FIRST))) begin
            nx_o.kind = HK_DATA;
            nx_o.idx  = half_d - half_t'(DATA_FIRST);
        end else if (active_d && (half_d >= half_t'(SYNC_FIRST))) begin
            nx_o.kind = HK_SYNC;
            nx_o.idx  = half_d - half_t'(SYNC_FIRST);
        end else if (pend_d) begin
            nx_o.kind = HK_PARITY;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            active_q <= 1'b0;
            half_q   <= '0;
            pend_q   <= 1'b0;
            cmd_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            half_q   <= half_d;
            pend_q   <= pend_d;
            // rising shift-clock edge of the lead-in period
            if (tick_i && active_d && (half_d == half_t'(1))) begin
                cmd_q <= sel_i;
            end
        end
    end

    assign cmd_o = cmd_q;
    assign req_o = active_q && (half_q >= half_t'(REQ_FIRST))
                            && (half_q <= half_t'(REQ_LAST));

    // R2: the half-bit counter stays inside one word cycle
    a_r2_half_range: assert property (@(posedge clk_i) disable iff (rst_i)
        active_q |-> (half_q <= half_t'(FRAME_HALVES - 1)));

    // R4: the request window opens at the start of bit period 3
    a_r4_req_open: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(req_o) |-> (half_q == half_t'(REQ_FIRST)));

    // R7: enable high at the end of a word restarts the cycle at once
    a_r7_back_to_back: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && last_half && en_i && !clr_i) |=> (active_q && half_q == '0));

    // R9: abort leaves no word in flight
    a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (!active_q && !pend_q && !req_o));

endmodule

// File: rtl/manch_bit_shaper.sv
module manch_bit_shaper
    import manch_enc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      clr_i,
    input  logic      tick_i,
    input  half_cmd_t nx_i,
    input  logic      cmd_i,
    input  logic      sdi_i,
    output logic      drive_o,
    output logic      lvl_o
);

    logic bit_q;
    logic acc_q;
    logic drive_q;
    logic lvl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            bit_q   <= 1'b0;
            acc_q   <= 1'b0;
            drive_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else if (tick_i) begin
            unique case (nx_i.kind)
                HK_SYNC: begin
                    drive_q <= 1'b1;
                    lvl_q   <= sync_level(cmd_i, nx_i.idx);
                end
                HK_DATA: begin
                    drive_q <= 1'b1;
                    if (nx_i.first) begin
                        lvl_q <= sdi_i;
                        bit_q <= sdi_i;
                        acc_q <= (nx_i.idx == '0) ? sdi_i : (acc_q ^ sdi_i);
                    end else begin
                        lvl_q <= ~bit_q;
                    end
                end
                HK_PARITY: begin
                    drive_q <= 1'b1;
                    lvl_q   <= nx_i.first ? odd_parity_bit(acc_q)
                                          : ~odd_parity_bit(acc_q);
                end
                default: begin
                    drive_q <= 1'b0;
                    lvl_q   <= 1'b0;
                end
            endcase
        end
    end

    assign drive_o = drive_q;
    assign lvl_o   = lvl_q;

    // R5: the second half of a data or parity bit inverts the first half
    a_r5_mid_invert: assert property (@(posedge clk_i) disable iff (rst_i || clr_i)
        (tick_i && !nx_i.first && (nx_i.kind == HK_DATA || nx_i.kind == HK_PARITY))
        |=> (lvl_o != $past(lvl_o)));

endmodule

// File: rtl/manch_encoder.sv
module manch_encoder
    import manch_enc_pkg::*;
#(
    parameter bit USE_PRESCALER = 1'b0,
    parameter int PRESCALE_DIV  = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mr_i,
    input  logic enc_en_i,
    input  logic sync_cmd_i,
    input  logic sdata_i,
    input  logic inhibit_n_i,
    output logic shift_clk_o,
    output logic data_req_o,
    output logic line_pos_o,
    output logic line_neg_o
);

    logic      tick;
    logic      ph;
    half_cmd_t nx;
    logic      cmd;
    logic      drive;
    logic      lvl;

    manch_half_tick #(
        .USE_PRESCALER(USE_PRESCALER),
        .DIV          (PRESCALE_DIV)
    ) i_tick (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (mr_i),
        .tick_o(tick),
        .ph_o  (ph)
    );

    manch_frame_seq i_seq (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (mr_i),
        .tick_i(tick),
        .ph_i  (ph),
        .en_i  (enc_en_i),
        .sel_i (sync_cmd_i),
        .nx_o  (nx),
        .cmd_o (cmd),
        .req_o (data_req_o)
    );

    manch_bit_shaper i_shaper (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (mr_i),
        .tick_i (tick),
        .nx_i   (nx),
        .cmd_i  (cmd),
        .sdi_i  (sdata_i),
        .drive_o(drive),
        .lvl_o  (lvl)
    );

    assign shift_clk_o = ph;
    assign line_pos_o  = ~inhibit_n_i | (drive & lvl);
    assign line_neg_o  = ~inhibit_n_i | (drive & ~lvl);

endmodule

// File: tb/test_manch_encoder.sv
module test_manch_encoder;

    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mr = 1'b0;
    logic en = 1'b0;
    logic sel = 1'b0;
    logic sdi = 1'b0;
    logic inh_n = 1'b1;
    logic esc, req, pos, neg;
    logic esc_d, req_d, pos_d, neg_d;

    always #(CLK_PERIOD / 2) clk = ~clk;

    manch_encoder i_manch_encoder (
        .clk_i(clk), .rst_i(rst), .mr_i(mr), .enc_en_i(en), .sync_cmd_i(sel),
        .sdata_i(sdi), .inhibit_n_i(inh_n), .shift_clk_o(esc), .data_req_o(req),
        .line_pos_o(pos), .line_neg_o(neg)
    );

    manch_encoder #(.USE_PRESCALER(1'b1)) i_manch_encoder_div (
        .clk_i(clk), .rst_i(rst), .mr_i(1'b0), .enc_en_i(1'b0), .sync_cmd_i(1'b0),
        .sdata_i(1'b0), .inhibit_n_i(1'b1), .shift_clk_o(esc_d), .data_req_o(req_d),
        .line_pos_o(pos_d), .line_neg_o(neg_d)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    logic [15:0] words [32];
    bit          sel_plan [32];
    int n_started = 0;
    int n_fed = 0;
    int bit_idx = 0;
    int req_run = 0;
    bit req_prev = 1'b0;
    bit abort_seen = 1'b0;

    // Reference model: queue of expected half-bit levels (2 = idle)
    int    lvl_q [$];
    string tag_q [$];
    int    exp_lvl = 2;
    string exp_tag = "R10";
    int    m_ph = 0;

    function automatic void push(input int l, input string t);
        lvl_q.push_back(l);
        tag_q.push_back(t);
    endfunction

    always @(posedge clk) begin
        if (rst || mr) begin
            lvl_q.delete();
            tag_q.delete();
            exp_lvl = 2;
            exp_tag = "R9";
            m_ph = 0;
        end else begin
            if (m_ph == 1 && en && lvl_q.size() <= 2) begin : start_blk
                logic [15:0] w;
                bit c;
                string st;
                w = words[n_started];
                c = sel_plan[n_started];
                n_started++;
                st = (lvl_q.size() == 0) ? "R3" : "R7";
                if (lvl_q.size() == 0) begin
                    push(2, "R2");
                    push(2, "R2");
                end
                for (int i = 0; i < 6; i++) push((i < 3) ? int'(c) : int'(!c), st);
                for (int b = 15; b >= 0; b--) begin
                    push(int'(w[b]), "R4/R5");
                    push(int'(!w[b]), "R5");
                end
                push(int'(~^w), "R6");
                push(int'(^w), "R6");
            end
            if (lvl_q.size() > 0) begin
                exp_lvl = lvl_q.pop_front();
                exp_tag = tag_q.pop_front();
            end else begin
                exp_lvl = 2;
                exp_tag = "R10";
            end
            m_ph = 1 - m_ph;
        end
    end

    int div_cnt = 0;
    int div_toggles = 0;
    logic esc_d_prev = 1'b0;

    // Output comparison and host-side serial feed, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int eo, ez;
            eo = !inh_n ? 1 : ((exp_lvl == 2) ? 0 : exp_lvl);
            ez = !inh_n ? 1 : ((exp_lvl == 2) ? 0 : 1 - exp_lvl);
            check(pos == eo[0] && neg == ez[0], inh_n ? exp_tag : "R8",
                  int'({pos, neg}), eo * 2 + ez);
            check(esc == m_ph[0], "R1", int'(esc), m_ph);

            if (req && !req_prev) begin
                n_fed++;
                bit_idx = 0;
                req_run = 0;
            end
            if (req) req_run++;
            if (!req && req_prev) begin
                if (!abort_seen) check(req_run == 32, "R4", req_run, 32);
                abort_seen = 1'b0;
            end
            if (req && esc && bit_idx < 16) begin
                sdi = words[n_fed - 1][15 - bit_idx];
                bit_idx++;
            end
            sel = sel_plan[n_fed];
            req_prev = req;

            // R11: prescaled instance toggles its shift clock every six clocks
            div_cnt++;
            if (esc_d != esc_d_prev) begin
                if (div_toggles > 0) check(div_cnt == 6, "R11", div_cnt, 6);
                div_toggles++;
                div_cnt = 0;
            end
            esc_d_prev = esc_d;
        end
    end

    initial begin
        words[0] = 16'hA5C3; sel_plan[0] = 1'b1;
        words[1] = 16'h0000; sel_plan[1] = 1'b0;
        words[2] = 16'hFFFF; sel_plan[2] = 1'b1;
        words[3] = 16'h0001; sel_plan[3] = 1'b0;
        for (int i = 4; i < 10; i++) begin
            words[i] = 16'($urandom);
            sel_plan[i] = 1'($urandom);
        end
        words[10] = 16'h8000; sel_plan[10] = 1'b1;
        words[11] = 16'h7FFE; sel_plan[11] = 1'b0;
        for (int i = 12; i < 32; i++) begin
            words[i] = '0;
            sel_plan[i] = 1'b0;
        end

        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R10: idle after reset, both line outputs low
        check(pos == 1'b0 && neg == 1'b0, "R10", int'({pos, neg}), 0);
        check(req == 1'b0, "R2 no request before a start", int'(req), 0);
        check(pos_d == 1'b0 && neg_d == 1'b0 && req_d == 1'b0, "R10 prescaled idle",
              int'({pos_d, neg_d, req_d}), 0);
        step(3);

        // single command word, enable dropped before the end (R2, R3, R7)
        en = 1'b1;
        wait (n_fed == 1);
        step(1);
        en = 1'b0;
        step(60);

        // back-to-back words with alternating sync and parity corners (R6, R7)
        en = 1'b1;
        wait (n_fed == 4);
        step(1);
        en = 1'b0;
        step(60);

        // random words back to back, inhibit pulse mid-frame (R8)
        en = 1'b1;
        wait (n_fed == 6);
        step(5);
        inh_n = 1'b0;
        step(12);
        inh_n = 1'b1;
        wait (n_fed == 10);
        step(1);
        en = 1'b0;
        step(60);

        // abort in the middle of the data bits (R9)
        en = 1'b1;
        wait (n_fed == 11);
        step(1);
        en = 1'b0;
        step(10);
        abort_seen = 1'b1;
        mr = 1'b1;
        step(1);
        mr = 1'b0;
        @(negedge clk);
        check(pos == 1'b0 && neg == 1'b0, "R9 line idle after abort", int'({pos, neg}), 0);
        check(req == 1'b0, "R9 request dropped after abort", int'(req), 0);
        step(50);

        // a data word after the abort encodes normally
        en = 1'b1;
        wait (n_fed == 12);
        step(1);
        en = 1'b0;
        step(60);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule